// File: doc/BRIEF.md
# Interrupt Presenter Thread-Context Matcher

This block takes one notification request from an upstream routing stage and searches for the hardware thread whose dispatched virtual-target context matches it. A request carries a format bit, an ignore bit, a target block, a target index, a logical-server number and a priority. The block joins the block and the index into one compare key. It reads a one-bit validity entry for the target from a small table. It then walks the thread contexts one per clock and compares the key against each thread's pool, OS and user ring words.

The result is one matching thread with its ring, or a status code that gives the reason for failure. Context words and table entries are loaded through a plain write port. A request starts with a one-cycle `start` pulse. `busy` stays high while the request is processed, and a one-cycle `done` pulse marks the result. The result outputs hold their values until the next accepted request.

Top module: `tctx_matcher`

## Requirements
- R1: The compare key is `{req_blk, req_idx}`, which is the block shifted left by IDX_W bits and ORed with the index. Ring compares use the full key, so a request that differs from a stored CAM only in its block bits does not match.
- R2: With format 0 and ignore 0, a thread whose pool word is valid (bit 31) and whose CAM (bits KEY_W-1:0) equals the key is reported as ring 2. This holds even when the same thread's OS word would also match.
- R3: With format 0 and ignore 0, a thread's OS word is checked only when its pool word fails. A valid OS word (bit 31) whose CAM equals the key is reported as ring 1. A pool word with a clear valid bit never matches, whatever its CAM holds.
- R4: A request with format 0 and ignore 1 whose target entry is valid ends with status 3 (unsupported) and match_valid low.
- R5: With format 1, a thread matches as ring 0 only when all four conditions hold: its OS word is valid, its OS CAM equals the key, its user word is valid, and the user field (bits LS_W-1:0) equals req_ls. With format 1 the ignore bit has no effect.
- R6: When a second thread matches during the scan, the request ends at once with status 4 (duplicate) and match_valid low.
- R7: When no thread matches after every thread has been scanned, the status is 5 (not dispatched) and match_valid is low.
- R8: The table entry number is req_idx. A req_idx of TBL_ENTRIES or more is a failed lookup: status 1, done one cycle after the accepting edge, and no scan.
- R9: A table entry whose stored bit 31 is clear gives status 2 (invalid target), with done one cycle after the accepting edge. This check takes precedence over the unsupported check of R4.
- R10: A successful or not-dispatched request raises done N_THREADS+1 cycles after the accepting edge. A duplicate found on thread j raises done j+2 cycles after it. busy and done are never high together.
- R11: match_valid drops to 0 at the edge that accepts a request. All result outputs stay unchanged from one done until the next accepted start.
- R12: res_prio returns the req_prio value captured at the accepting edge. Priority has no effect on the result.
- R13: After reset, busy, done, match_valid and status are 0, and match_ring is 3 (none).
- R14: Writes with wr_tbl=0 address context word wr_addr: the thread is wr_addr/4, and the low two bits select the user (0), OS (1) or pool (2) word. Writes with wr_tbl=1 set the valid bit of table entry wr_addr from wr_data[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_tbl | input | 1 | 1 = target table, 0 = thread contexts |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| start | input | 1 | Request strobe, accepted when idle |
| req_fmt | input | 1 | Format bit |
| req_ign | input | 1 | Ignore (logical-server) bit |
| req_blk | input | BLK_W | Target block |
| req_idx | input | IDX_W | Target index |
| req_ls | input | LS_W | Logical-server number |
| req_prio | input | PRIO_W | Priority, passed through |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| match_valid | output | 1 | A single thread matched |
| match_thread | output | THR_W | Matching thread number |
| match_ring | output | 2 | 0 user, 1 OS, 2 pool, 3 none |
| status | output | 3 | 0 ok, 1 no target, 2 invalid, 3 unsupported, 4 duplicate, 5 not dispatched |
| res_prio | output | PRIO_W | Captured priority |

## Verification
The bench builds the block with four threads, an eight-entry table, a 4-bit block and a 19-bit index. With four threads, a duplicate can sit two threads after the first hit, which is enough to show the early stop apart from the full walk. With a 4-bit block, the keys reach past bit 19, so a mismatch in the block bits alone can be tested. With an eight-entry table, one invalid entry and an index beyond the end can both be reached with small numbers.

// File: rtl/tctx_match_pkg.sv
package tctx_match_pkg;

  typedef enum logic [2:0] {
    ST_OK             = 3'd0,
    ST_NO_TARGET      = 3'd1,
    ST_INVALID        = 3'd2,
    ST_UNSUPPORTED    = 3'd3,
    ST_DUPLICATE      = 3'd4,
    ST_NOT_DISPATCHED = 3'd5
  } status_e;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_NONE = 2'd3
  } ring_e;

  // Word select in the low two address bits of a context write
  localparam logic [1:0] WSEL_USER = 2'd0;
  localparam logic [1:0] WSEL_OS   = 2'd1;
  localparam logic [1:0] WSEL_POOL = 2'd2;

  // Ring choice for one thread, given the per-word valid bits and compares
  function automatic ring_e ctx_ring(input logic fmt,
                                     input logic pool_v, input logic pool_eq,
                                     input logic os_v,   input logic os_eq,
                                     input logic usr_v,  input logic ls_eq);
    ring_e r;
    r = RING_NONE;
    if (!fmt) begin
      if (pool_v && pool_eq)    r = RING_POOL;
      else if (os_v && os_eq)   r = RING_OS;
    end else if (os_v && os_eq && usr_v && ls_eq) begin
      r = RING_USER;
    end
    return r;
  endfunction

endpackage

// File: rtl/tctx_thread_cmp.sv
module tctx_thread_cmp
  import tctx_match_pkg::*;
#(
  parameter int KEY_W = 23,
  parameter int LS_W  = 8
) (
  input  logic             fmt,
  input  logic [KEY_W-1:0] key,
  input  logic [LS_W-1:0]  ls,
  input  logic             pool_v,
  input  logic [KEY_W-1:0] pool_cam,
  input  logic             os_v,
  input  logic [KEY_W-1:0] os_cam,
  input  logic             usr_v,
  input  logic [LS_W-1:0]  usr_ls,
  output logic [1:0]       ring
);
  logic pool_eq, os_eq, ls_eq;

  assign pool_eq = (pool_cam == key);
  assign os_eq   = (os_cam == key);
  assign ls_eq   = (usr_ls == ls);
  assign ring    = ctx_ring(fmt, pool_v, pool_eq, os_v, os_eq, usr_v, ls_eq);
endmodule

// File: rtl/tctx_ctx_bank.sv
module tctx_ctx_bank
  import tctx_match_pkg::*;
#(
  parameter int N_THREADS = 4,
  parameter int KEY_W     = 23,
  parameter int LS_W      = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       fmt,
  input  logic [KEY_W-1:0]           key,
  input  logic [LS_W-1:0]            ls,
  output logic [N_THREADS-1:0][1:0]  hit_ring
);
  localparam int HI_USED = (KEY_W > LS_W) ? KEY_W : LS_W;

  logic       unused_wr_bits;
  logic [1:0] wsel;

  assign unused_wr_bits = ^wr_data[30:HI_USED];
  assign wsel           = wr_addr[1:0];

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    logic             pool_v, os_v, usr_v;
    logic [KEY_W-1:0] pool_cam, os_cam;
    logic [LS_W-1:0]  usr_ls;
    logic             sel;

    assign sel = wr_en && ((wr_addr >> 2) == ADDR_W'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pool_v <= 1'b0; pool_cam <= '0;
        os_v   <= 1'b0; os_cam   <= '0;
        usr_v  <= 1'b0; usr_ls   <= '0;
      end else if (sel) begin
        case (wsel)
          WSEL_POOL: begin pool_v <= wr_data[31]; pool_cam <= wr_data[KEY_W-1:0]; end
          WSEL_OS:   begin os_v   <= wr_data[31]; os_cam   <= wr_data[KEY_W-1:0]; end
          WSEL_USER: begin usr_v  <= wr_data[31]; usr_ls   <= wr_data[LS_W-1:0];  end
          default: ;
        endcase
      end
    end

    tctx_thread_cmp #(.KEY_W(KEY_W), .LS_W(LS_W)) u_cmp (
      .fmt(fmt), .key(key), .ls(ls),
      .pool_v(pool_v), .pool_cam(pool_cam),
      .os_v(os_v), .os_cam(os_cam),
      .usr_v(usr_v), .usr_ls(usr_ls),
      .ring(hit_ring[t])
    );
  end
endmodule

// File: rtl/tctx_tgt_table.sv
module tctx_tgt_table #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 19,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  idx,
  output logic              found,
  output logic              entry_valid
);
  localparam int TA = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vbits;
  logic [TA-1:0]      rd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vbits <= '0;
    else begin
      for (int e = 0; e < ENTRIES; e++)
        if (wr_en && wr_addr == ADDR_W'(e)) vbits[e] <= wr_valid;
    end
  end

  assign found       = (32'(idx) < 32'(ENTRIES));
  assign rd_sel      = idx[TA-1:0];
  assign entry_valid = found && vbits[rd_sel];
endmodule

// File: rtl/tctx_matcher.sv
module tctx_matcher
  import tctx_match_pkg::*;
#(
  parameter int N_THREADS   = 4,
  parameter int BLK_W       = 4,
  parameter int IDX_W       = 19,
  parameter int LS_W        = 8,
  parameter int PRIO_W      = 3,
  parameter int TBL_ENTRIES = 8,
  localparam int KEY_W  = BLK_W + IDX_W,
  localparam int THR_W  = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int CTX_AW = THR_W + 2,
  localparam int TBL_AW = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1,
  localparam int ADDR_W = (CTX_AW > TBL_AW) ? CTX_AW : TBL_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_tbl,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              start,
  input  logic              req_fmt,
  input  logic              req_ign,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [LS_W-1:0]   req_ls,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              busy,
  output logic              done,
  output logic              match_valid,
  output logic [THR_W-1:0]  match_thread,
  output logic [1:0]        match_ring,
  output logic [2:0]        status,
  output logic [PRIO_W-1:0] res_prio
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_SCAN} state_e;

  state_e state;

  logic             r_fmt, r_ign;
  logic [BLK_W-1:0] r_blk;
  logic [IDX_W-1:0] r_idx;
  logic [LS_W-1:0]  r_ls;
  logic [KEY_W-1:0] key;

  logic [THR_W-1:0] scan_cnt, found_thr;
  logic             found;
  ring_e            found_ring;

  logic [N_THREADS-1:0][1:0] hit_ring;
  ring_e            cur_ring;
  logic             tbl_found, tbl_valid;

  logic             r_mv;
  logic [THR_W-1:0] r_thr;
  ring_e            r_ring;
  status_e          r_status;
  logic [PRIO_W-1:0] r_prio;

  // Named internal events, observed by the checker
  logic    evt_accept, evt_lookup, evt_finish, scan_hit, scan_last;
  logic    fin_mv;
  status_e fin_st;
  logic [THR_W-1:0] fin_thr;
  ring_e   fin_ring;

  assign key = {r_blk, r_idx};

  tctx_ctx_bank #(
    .N_THREADS(N_THREADS), .KEY_W(KEY_W), .LS_W(LS_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wr_tbl), .wr_addr(wr_addr), .wr_data(wr_data),
    .fmt(r_fmt), .key(key), .ls(r_ls),
    .hit_ring(hit_ring)
  );

  tctx_tgt_table #(
    .ENTRIES(TBL_ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_tbl), .wr_addr(wr_addr), .wr_valid(wr_data[31]),
    .idx(r_idx), .found(tbl_found), .entry_valid(tbl_valid)
  );

  assign cur_ring   = ring_e'(hit_ring[scan_cnt]);
  assign evt_accept = start && (state == S_IDLE);
  assign evt_lookup = (state == S_LOOK);
  assign scan_hit   = (state == S_SCAN) && (cur_ring != RING_NONE);
  assign scan_last  = (scan_cnt == THR_W'(N_THREADS - 1));

  always_comb begin
    evt_finish = 1'b0;
    fin_st     = ST_OK;
    fin_mv     = 1'b0;
    fin_thr    = '0;
    fin_ring   = RING_NONE;
    case (state)
      S_LOOK: begin
        if (!tbl_found) begin
          evt_finish = 1'b1; fin_st = ST_NO_TARGET;
        end else if (!tbl_valid) begin
          evt_finish = 1'b1; fin_st = ST_INVALID;
        end else if (!r_fmt && r_ign) begin
          evt_finish = 1'b1; fin_st = ST_UNSUPPORTED;
        end
      end
      S_SCAN: begin
        if (scan_hit && found) begin
          evt_finish = 1'b1; fin_st = ST_DUPLICATE;
        end else if (scan_last) begin
          evt_finish = 1'b1;
          if (found) begin
            fin_mv = 1'b1; fin_thr = found_thr; fin_ring = found_ring;
          end else if (scan_hit) begin
            fin_mv = 1'b1; fin_thr = scan_cnt; fin_ring = cur_ring;
          end else begin
            fin_st = ST_NOT_DISPATCHED;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      r_fmt      <= 1'b0;
      r_ign      <= 1'b0;
      r_blk      <= '0;
      r_idx      <= '0;
      r_ls       <= '0;
      scan_cnt   <= '0;
      found      <= 1'b0;
      found_thr  <= '0;
      found_ring <= RING_NONE;
      done       <= 1'b0;
      r_mv       <= 1'b0;
      r_thr      <= '0;
      r_ring     <= RING_NONE;
      r_status   <= ST_OK;
      r_prio     <= '0;
    end else begin
      done <= evt_finish;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_LOOK;
          r_fmt    <= req_fmt;
          r_ign    <= req_ign;
          r_blk    <= req_blk;
          r_idx    <= req_idx;
          r_ls     <= req_ls;
          r_prio   <= req_prio;
          scan_cnt <= '0;
          found    <= 1'b0;
          r_mv     <= 1'b0;
          r_thr    <= '0;
          r_ring   <= RING_NONE;
          r_status <= ST_OK;
        end
        S_LOOK: state <= evt_finish ? S_IDLE : S_SCAN;
        S_SCAN: begin
          if (scan_hit) begin
            found      <= 1'b1;
            found_thr  <= scan_cnt;
            found_ring <= cur_ring;
          end
          scan_cnt <= scan_cnt + 1'b1;
          if (evt_finish) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (evt_finish) begin
        r_mv     <= fin_mv;
        r_thr    <= fin_thr;
        r_ring   <= fin_ring;
        r_status <= fin_st;
      end
    end
  end

  assign busy         = (state != S_IDLE);
  assign match_valid  = r_mv;
  assign match_thread = r_thr;
  assign match_ring   = r_ring;
  assign status       = r_status;
  assign res_prio     = r_prio;
endmodule

// File: rtl/tctx_matcher_chk.sv
module tctx_matcher_chk #(
  parameter int THR_W  = 2,
  parameter int PRIO_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              match_valid,
  input logic [THR_W-1:0]  match_thread,
  input logic [1:0]        match_ring,
  input logic [2:0]        status,
  input logic [PRIO_W-1:0] res_prio,
  input logic [PRIO_W-1:0] req_prio,
  input logic              evt_accept,
  input logic              evt_lookup,
  input logic              evt_finish
);
  assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_after_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_finish |=> done);

  assert_match_ok_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> status == 3'd0);

  assert_match_ring_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |-> match_ring != 2'd3);

  assert_dup_no_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> !match_valid);

  assert_early_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == 3'd1 || status == 3'd2 || status == 3'd3)) |-> $past(evt_lookup));

  assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_accept || evt_finish) |=>
      $stable({match_valid, match_thread, match_ring, status, res_prio}));

  assert_prio_capture_R12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> res_prio == $past(req_prio));
endmodule

bind tctx_matcher tctx_matcher_chk #(.THR_W(THR_W), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .match_valid(match_valid), .match_thread(match_thread),
  .match_ring(match_ring), .status(status), .res_prio(res_prio),
  .req_prio(req_prio), .evt_accept(evt_accept), .evt_lookup(evt_lookup),
  .evt_finish(evt_finish)
);

// File: tb/tctx_matcher_tb.sv
`timescale 1ns/1ps
module tctx_matcher_tb;
  localparam int N_THREADS = 4;
  localparam int BLK_W = 4, IDX_W = 19, LS_W = 8, PRIO_W = 3, TBL_ENTRIES = 8;
  localparam int ADDR_W = 4;
  localparam logic [31:0] V = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_tbl = 0, start = 0, req_fmt = 0, req_ign = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [BLK_W-1:0] req_blk = '0;
  logic [IDX_W-1:0] req_idx = '0;
  logic [LS_W-1:0] req_ls = '0;
  logic [PRIO_W-1:0] req_prio = '0;
  logic busy, done, match_valid;
  logic [1:0] match_thread, match_ring;
  logic [2:0] status;
  logic [PRIO_W-1:0] res_prio;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tctx_matcher #(.N_THREADS(N_THREADS), .BLK_W(BLK_W), .IDX_W(IDX_W), .LS_W(LS_W),
                 .PRIO_W(PRIO_W), .TBL_ENTRIES(TBL_ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .req_fmt(req_fmt), .req_ign(req_ign),
    .req_blk(req_blk), .req_idx(req_idx), .req_ls(req_ls), .req_prio(req_prio),
    .busy(busy), .done(done), .match_valid(match_valid), .match_thread(match_thread),
    .match_ring(match_ring), .status(status), .res_prio(res_prio));

  function automatic logic [31:0] key(input int b, input int i);
    return (32'(b) << IDX_W) | 32'(i);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic tbl, input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_tbl = tbl; wr_addr = ADDR_W'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  typedef struct packed {
    logic       fmt;
    logic       ign;
    logic [3:0] blk;
    logic [18:0] idx;
    logic [7:0] ls;
    logic [2:0] prio;
    logic [2:0] st;
    logic       mv;
    logic [1:0] thr;
    logic [1:0] ring;
    logic [3:0] lat;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'd1,19'd2,8'h00,3'd1, 3'd4,1'b0,2'd0,2'd3,4'd4,4'd6},  // R6 dup T0 pool, T2 OS
    '{1'b0,1'b0,4'd3,19'd1,8'h00,3'd2, 3'd0,1'b1,2'd1,2'd1,4'd5,4'd3},  // R3 pool invalid -> OS
    '{1'b0,1'b0,4'd5,19'd3,8'h00,3'd3, 3'd0,1'b1,2'd3,2'd2,4'd5,4'd2},  // R2 pool before OS
    '{1'b0,1'b0,4'd2,19'd4,8'h00,3'd4, 3'd0,1'b1,2'd2,2'd2,4'd5,4'd1},  // R1 block in key
    '{1'b0,1'b0,4'd3,19'd4,8'h00,3'd5, 3'd5,1'b0,2'd0,2'd3,4'd5,4'd1},  // R1 block differs
    '{1'b0,1'b0,4'd3,19'd0,8'h00,3'd6, 3'd0,1'b1,2'd0,2'd1,4'd5,4'd3},  // R3 OS fallback
    '{1'b1,1'b0,4'd3,19'd1,8'h5A,3'd7, 3'd0,1'b1,2'd1,2'd0,4'd5,4'd5},  // R5 user match
    '{1'b1,1'b1,4'd3,19'd1,8'h5A,3'd0, 3'd0,1'b1,2'd1,2'd0,4'd5,4'd5},  // R5 ignore no effect
    '{1'b1,1'b0,4'd3,19'd1,8'h5B,3'd1, 3'd5,1'b0,2'd0,2'd3,4'd5,4'd5},  // R5 LS mismatch
    '{1'b1,1'b0,4'd3,19'd0,8'h00,3'd2, 3'd5,1'b0,2'd0,2'd3,4'd5,4'd5},  // R5 user invalid
    '{1'b1,1'b0,4'd1,19'd2,8'h11,3'd3, 3'd0,1'b1,2'd2,2'd0,4'd5,4'd5},  // R5 user on T2
    '{1'b0,1'b1,4'd3,19'd1,8'h00,3'd4, 3'd3,1'b0,2'd0,2'd3,4'd1,4'd4},  // R4 unsupported
    '{1'b0,1'b0,4'd0,19'd6,8'h00,3'd5, 3'd2,1'b0,2'd0,2'd3,4'd1,4'd9},  // R9 invalid entry
    '{1'b0,1'b1,4'd0,19'd6,8'h00,3'd6, 3'd2,1'b0,2'd0,2'd3,4'd1,4'd9},  // R9 before R4
    '{1'b0,1'b0,4'd3,19'd9,8'h00,3'd7, 3'd1,1'b0,2'd0,2'd3,4'd1,4'd8},  // R8 no target
    '{1'b0,1'b0,4'd7,19'd7,8'h00,3'd0, 3'd5,1'b0,2'd0,2'd3,4'd5,4'd7}   // R7 not dispatched
  };

  task automatic run_req(input vec_t v);
    string rq;
    int lat;
    logic [31:0] snap;
    rq = $sformatf("R%0d", v.rq);
    @(negedge clk);
    req_fmt = v.fmt; req_ign = v.ign; req_blk = v.blk; req_idx = v.idx;
    req_ls = v.ls; req_prio = v.prio; start = 1;
    @(negedge clk);
    start = 0;
    chk(match_valid == 1'b0, "R11", "match_valid cleared at accept", 32'(match_valid), 0);
    lat = 0;
    while (1) begin
      if (done) break;
      if (lat > 40) begin
        chk(0, rq, "done timeout", 32'(lat), 32'(v.lat));
        break;
      end
      @(negedge clk);
      lat++;
    end
    chk(lat == int'(v.lat), "R10", {rq, " latency"}, 32'(lat), 32'(v.lat));
    chk(status == v.st, rq, "status", 32'(status), 32'(v.st));
    chk(match_valid == v.mv, rq, "match_valid", 32'(match_valid), 32'(v.mv));
    chk(match_ring == v.ring, rq, "ring", 32'(match_ring), 32'(v.ring));
    if (v.mv) chk(match_thread == v.thr, rq, "thread", 32'(match_thread), 32'(v.thr));
    chk(res_prio == v.prio, "R12", "priority echo", 32'(res_prio), 32'(v.prio));
    snap = {20'd0, match_valid, match_thread, match_ring, status, res_prio, 1'b0};
    repeat (3) @(negedge clk);
    chk({20'd0, match_valid, match_thread, match_ring, status, res_prio, 1'b0} == snap,
        "R11", "result hold while idle",
        {20'd0, match_valid, match_thread, match_ring, status, res_prio, 1'b0}, snap);
  endtask

  initial begin
    #500_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(busy == 0, "R13", "busy", 32'(busy), 0);
    chk(done == 0, "R13", "done", 32'(done), 0);
    chk(match_valid == 0, "R13", "match_valid", 32'(match_valid), 0);
    chk(status == 0, "R13", "status", 32'(status), 0);
    chk(match_ring == 2'd3, "R13", "ring", 32'(match_ring), 3);
    rst_n = 1;

    // R14 load table and contexts
    for (int e = 0; e < TBL_ENTRIES; e++) wr(1'b1, e, (e == 6) ? 32'h0 : V);
    wr(1'b0, 0*4+0, 32'h0);
    wr(1'b0, 0*4+1, V | key(3,0));
    wr(1'b0, 0*4+2, V | key(1,2));
    wr(1'b0, 1*4+0, V | 32'h5A);
    wr(1'b0, 1*4+1, V | key(3,1));
    wr(1'b0, 1*4+2, key(3,1));
    wr(1'b0, 2*4+0, V | 32'h11);
    wr(1'b0, 2*4+1, V | key(1,2));
    wr(1'b0, 2*4+2, V | key(2,4));
    wr(1'b0, 3*4+0, 32'h0);
    wr(1'b0, 3*4+1, V | key(5,3));
    wr(1'b0, 3*4+2, V | key(5,3));
    wr(1'b0, 0*4+3, V | key(7,7));  // R14 word select 3 holds nothing

    for (int k = 0; k < NV; k++) run_req(VECS[k]);

    // R2 / R14: make T1 pool valid, pool now wins on T1
    wr(1'b0, 1*4+2, V | key(3,1));
    run_req('{1'b0,1'b0,4'd3,19'd1,8'h00,3'd5, 3'd0,1'b1,2'd1,2'd2,4'd5,4'd2});
    // R3: clear both T1 pool and OS valid -> nothing left for key(3,1)
    wr(1'b0, 1*4+2, key(3,1));
    wr(1'b0, 1*4+1, key(3,1));
    run_req('{1'b0,1'b0,4'd3,19'd1,8'h00,3'd2, 3'd5,1'b0,2'd0,2'd3,4'd5,4'd3});
    // R9 / R14: invalidate table entry 5 through the table write port
    wr(1'b1, 5, 32'h7FFF_FFFF);
    run_req('{1'b0,1'b0,4'd0,19'd5,8'h00,3'd1, 3'd2,1'b0,2'd0,2'd3,4'd1,4'd9});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule